// File: doc/BRIEF.md
# Filtered power-on reset supervisor

This block turns a single "supply good" bit from an external comparator into a clean, active-low reset for the rest of the chip. The bit is sampled on a free-running clock. A saturating up/down integrator filters it, so a disturbance lowers reset only if it is both deep enough and long enough. Momentary load steps and short brownouts therefore leave reset alone.

The reset path is deliberately lopsided. A filtered fault drops reset one cycle after the filter declares it. Recovery is different: once the filter declares the supply good, a programmable release delay must run to completion before reset goes high. If a filtered fault arrives while that delay is running, the delay is abandoned and starts again from the beginning on the next recovery.

The controller has three states:
- `ST_HOLD`: reset low, waiting for a filtered "good".
- `ST_RELEASE`: reset low, delay timer running.
- `ST_RUN`: reset high.

It has five transitions:
- HOLD→RUN (filtered good, delay of one).
- HOLD→RELEASE (filtered good, longer delay).
- RELEASE→RUN (delay expired).
- RELEASE→HOLD (abort on filtered fault).
- RUN→HOLD (fault).

Top module: `por_supervisor`

## Requirements
- R1: While `clr_n` is low, `rst_n` is 0. After `clr_n` rises, `rst_n` stays 0 until the full release sequence of R3 has completed, because the integrator starts at its fault limit.
- R2: The integrator moves by exactly one per clock: up on a bad sample (`sup_ok`=0) and down on a good sample (`sup_ok`=1). It saturates at 0 and at L, where L is `cfg_limit` (0 acts as 1). The fault flag sets when the count reaches L, clears when it reaches 0, and otherwise keeps its value.
- R3: Start from a clear, with `sup_ok`=1 from the first rising edge on. Then `rst_n` is 0 through rising edge L+D−1 and reads 1 after rising edge L+D, where D is `cfg_delay` (0 acts as 1).
- R4: Start from the run state with the integrator at zero. A continuous run of bad samples drives `rst_n` to 0 after rising edge L+1, with no delay timer on this path.
- R5: Bursts of L−1 bad samples, each followed by L−1 good samples, never lower `rst_n`.
- R6: A 1:1 alternation of bad and good samples never lowers `rst_n`. A repeating pattern of bad, bad, good that starts from a zero count lowers `rst_n` after rising edge 3L−3 (for L≥2).
- R7: A filtered fault during the release delay returns the controller to hold, and the delay restarts from zero. After a saturated fault, `rst_n` rises again exactly L+D edges after good samples resume.
- R8: `cfg_limit`=0 and `cfg_delay`=0 behave as 1. In that case `rst_n` rises after the 2nd good edge following a clear, and falls after the 2nd bad edge from run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running sampling clock |
| clr_n | input | 1 | Asynchronous power-up clear, active low |
| sup_ok | input | 1 | Comparator result, 1 = supply above threshold |
| cfg_limit | input | FLT_W | Integrator limit L (0 acts as 1) |
| cfg_delay | input | DLY_W | Release delay D in clock cycles (0 acts as 1) |
| rst_n | output | 1 | Active-low reset to the system |

## Verification
The assertions assume three things about the inputs:
- `cfg_limit` and `cfg_delay` change only while `clr_n` is low.
- `sup_ok` is already synchronous to `clk`.
- The count bound compared against L only holds when L does not move under a live count.

The bench follows these rules. It writes a new configuration only inside a clear pulse, and it changes `sup_ok` and `clr_n` only on the falling clock edge.

// File: rtl/por_pkg.sv
package por_pkg;

    typedef enum logic [1:0] {
        ST_HOLD    = 2'd0,
        ST_RELEASE = 2'd1,
        ST_RUN     = 2'd2
    } por_state_e;

endpackage

// File: rtl/por_integrator.sv
module por_integrator #(
    parameter int FLT_W = 8
) (
    input  logic             clk,
    input  logic             clr_n,
    input  logic             sup_ok_i,
    input  logic [FLT_W-1:0] cfg_limit_i,
    output logic             flt_bad_o
);
    localparam logic [FLT_W-1:0] CNT_TOP = {FLT_W{1'b1}};
    localparam logic [FLT_W-1:0] ONE     = FLT_W'(1);

    logic [FLT_W-1:0] lim;
    logic [FLT_W-1:0] cnt_q;
    logic [FLT_W-1:0] cnt_eff;
    logic [FLT_W-1:0] cnt_n;
    logic             flag_q;
    logic             flag_n;

    // zero limit behaves as one
    always_comb begin
        lim = (cfg_limit_i == '0) ? ONE : cfg_limit_i;
    end

    // clamp the post-clear value down to the programmed limit
    always_comb begin
        cnt_eff = (cnt_q > lim) ? lim : cnt_q;
        if (sup_ok_i) begin
            cnt_n = (cnt_eff == '0) ? '0 : cnt_eff - ONE;
        end else begin
            cnt_n = (cnt_eff == lim) ? lim : cnt_eff + ONE;
        end
    end

    // hysteresis: set at the limit, clear at zero
    always_comb begin
        flag_n = flag_q;
        if (cnt_n == lim) begin
            flag_n = 1'b1;
        end else if (cnt_n == '0) begin
            flag_n = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) begin
            cnt_q  <= CNT_TOP;
            flag_q <= 1'b1;
        end else begin
            cnt_q  <= cnt_n;
            flag_q <= flag_n;
        end
    end

    assign flt_bad_o = flag_q;

    p_good_below_limit_r2: assert property (@(posedge clk) disable iff (!clr_n)
        sup_ok_i |=> (cnt_q < lim));

    p_flag_rise_at_limit_r2: assert property (@(posedge clk) disable iff (!clr_n)
        $rose(flag_q) |-> (cnt_q == lim));

    p_flag_fall_at_zero_r2: assert property (@(posedge clk) disable iff (!clr_n)
        $fell(flag_q) |-> (cnt_q == '0));

    p_single_bad_no_flag_r5: assert property (@(posedge clk) disable iff (!clr_n)
        (!flag_q && cnt_q == '0 && lim > ONE) |=> !flag_q);

endmodule

// File: rtl/por_delay_timer.sv
module por_delay_timer #(
    parameter int DLY_W = 16
) (
    input  logic             clk,
    input  logic             clr_n,
    input  logic             load_i,
    input  logic             step_i,
    input  logic [DLY_W-1:0] cfg_delay_i,
    output logic             short_o,
    output logic             expired_o
);
    localparam logic [DLY_W-1:0] ONE  = DLY_W'(1);
    localparam logic [DLY_W:0]   ONEW = (DLY_W+1)'(1);

    logic [DLY_W-1:0] tmr_q;
    logic [DLY_W-1:0] dly_eff;
    logic [DLY_W:0]   tmr_inc;

    always_comb begin
        dly_eff   = (cfg_delay_i == '0) ? ONE : cfg_delay_i;
        short_o   = (dly_eff == ONE);
        tmr_inc   = {1'b0, tmr_q} + ONEW;
        expired_o = (tmr_inc >= {1'b0, dly_eff});
    end

    // load counts the cycle spent leaving hold as the first delay cycle
    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) begin
            tmr_q <= '0;
        end else if (load_i) begin
            tmr_q <= ONE;
        end else if (step_i && !expired_o) begin
            tmr_q <= tmr_inc[DLY_W-1:0];
        end else if (!step_i) begin
            tmr_q <= '0;
        end
    end

    p_tmr_bound_r3: assert property (@(posedge clk) disable iff (!clr_n)
        tmr_q <= dly_eff);

    p_load_restart_r7: assert property (@(posedge clk) disable iff (!clr_n)
        load_i |=> (tmr_q == ONE));

    p_idle_cleared_r7: assert property (@(posedge clk) disable iff (!clr_n)
        (!load_i && !step_i) |=> (tmr_q == '0));

endmodule

// File: rtl/por_fsm.sv
module por_fsm
    import por_pkg::*;
(
    input  logic clk,
    input  logic clr_n,
    input  logic flt_bad_i,
    input  logic short_i,
    input  logic expired_i,
    output logic load_o,
    output logic step_o,
    output logic rst_n_o
);
    por_state_e state_q;
    por_state_e state_n;

    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_HOLD: begin
                if (!flt_bad_i) begin
                    state_n = short_i ? ST_RUN : ST_RELEASE;
                end
            end
            ST_RELEASE: begin
                if (flt_bad_i) begin
                    state_n = ST_HOLD;
                end else if (expired_i) begin
                    state_n = ST_RUN;
                end
            end
            ST_RUN: begin
                if (flt_bad_i) begin
                    state_n = ST_HOLD;
                end
            end
            default: state_n = ST_HOLD;
        endcase
    end

    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) begin
            state_q <= ST_HOLD;
        end else begin
            state_q <= state_n;
        end
    end

    // registered reset output, glitch free
    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) begin
            rst_n_o <= 1'b0;
        end else begin
            rst_n_o <= (state_n == ST_RUN);
        end
    end

    always_comb begin
        load_o = (state_q == ST_HOLD) && !flt_bad_i && !short_i;
        step_o = (state_q == ST_RELEASE) && !flt_bad_i;
    end

    p_fault_hold_r4: assert property (@(posedge clk) disable iff (!clr_n)
        (flt_bad_i && state_q != ST_HOLD) |=> (!rst_n_o && state_q == ST_HOLD));

    p_rise_needs_good_r3: assert property (@(posedge clk) disable iff (!clr_n)
        $rose(rst_n_o) |-> $past(!flt_bad_i));

    p_abort_release_r7: assert property (@(posedge clk) disable iff (!clr_n)
        (state_q == ST_RELEASE && flt_bad_i) |=> (state_q == ST_HOLD));

    p_low_outside_run_r1: assert property (@(posedge clk) disable iff (!clr_n)
        (state_q != ST_RUN) |-> !rst_n_o);

endmodule

// File: rtl/por_supervisor.sv
module por_supervisor #(
    parameter int FLT_W = 8,
    parameter int DLY_W = 16
) (
    input  logic             clk,
    input  logic             clr_n,
    input  logic             sup_ok,
    input  logic [FLT_W-1:0] cfg_limit,
    input  logic [DLY_W-1:0] cfg_delay,
    output logic             rst_n
);
    logic flt_bad;
    logic load;
    logic step;
    logic short_dly;
    logic expired;

    por_integrator #(.FLT_W(FLT_W)) u_integ (
        .clk        (clk),
        .clr_n      (clr_n),
        .sup_ok_i   (sup_ok),
        .cfg_limit_i(cfg_limit),
        .flt_bad_o  (flt_bad)
    );

    por_delay_timer #(.DLY_W(DLY_W)) u_timer (
        .clk        (clk),
        .clr_n      (clr_n),
        .load_i     (load),
        .step_i     (step),
        .cfg_delay_i(cfg_delay),
        .short_o    (short_dly),
        .expired_o  (expired)
    );

    por_fsm u_fsm (
        .clk      (clk),
        .clr_n    (clr_n),
        .flt_bad_i(flt_bad),
        .short_i  (short_dly),
        .expired_i(expired),
        .load_o   (load),
        .step_o   (step),
        .rst_n_o  (rst_n)
    );

endmodule

// File: tb/por_supervisor_bench.sv
module por_supervisor_bench;
    localparam int FW = 8;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          clr_n;
    logic          sup_ok;
    logic [FW-1:0] lim;
    logic [DW-1:0] dly;
    logic          rst_n;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    por_supervisor #(.FLT_W(FW), .DLY_W(DW)) u_por_supervisor (
        .clk      (clk),
        .clr_n    (clr_n),
        .sup_ok   (sup_ok),
        .cfg_limit(lim),
        .cfg_delay(dly),
        .rst_n    (rst_n)
    );

    function automatic int eff(int v);
        return (v == 0) ? 1 : v;
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step(int n);
        repeat (n) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic edges_until(logic level, int maxn, output int k);
        k = -1;
        for (int i = 1; i <= maxn; i++) begin
            step(1);
            if (rst_n == level) begin
                k = i;
                break;
            end
        end
    endtask

    // R1 / R3: clear, then good supply; rise on edge L+D exactly
    task automatic t_powerup(int l, int d);
        int k;
        @(negedge clk);
        clr_n = 1'b0;
        sup_ok = 1'b0;
        lim = FW'(l);
        dly = DW'(d);
        #1;
        chk(rst_n == 1'b0, "R1 low during clear", int'(rst_n), 0);
        step(2);
        clr_n = 1'b1;
        step(3);
        chk(rst_n == 1'b0, "R1 low after clear, supply bad", int'(rst_n), 0);
        sup_ok = 1'b1;
        edges_until(1'b1, eff(l) + eff(d) + 20, k);
        if (eff(l) == 1 && eff(d) == 1) begin
            chk(k == 2, "R8 degenerate release edge", k, 2);
        end else begin
            chk(k == eff(l) + eff(d), "R3 release edge", k, eff(l) + eff(d));
        end
    endtask

    // R4 / R8: from run, continuous bad; low after edge L+1
    task automatic t_fault(int l);
        int k;
        sup_ok = 1'b0;
        edges_until(1'b0, eff(l) + 20, k);
        if (eff(l) == 1) begin
            chk(k == 2, "R8 degenerate fault edge", k, 2);
        end else begin
            chk(k == eff(l) + 1, "R4 fault edge", k, eff(l) + 1);
        end
        step(3);
    endtask

    // R5: sub-limit bursts never reset
    task automatic t_transient(int l);
        int lows = 0;
        for (int b = 0; b < 20; b++) begin
            sup_ok = 1'b0;
            for (int i = 0; i < l - 1; i++) begin
                step(1);
                if (!rst_n) lows++;
            end
            sup_ok = 1'b1;
            for (int i = 0; i < l - 1; i++) begin
                step(1);
                if (!rst_n) lows++;
            end
        end
        chk(lows == 0, "R5 short bursts leave reset high", lows, 0);
    endtask

    // R2: count goes down by exactly one per good sample
    task automatic t_updown(int l);
        int k;
        int lows = 0;
        sup_ok = 1'b0;
        for (int i = 0; i < l - 1; i++) begin
            step(1);
            if (!rst_n) lows++;
        end
        sup_ok = 1'b1;
        step(1);
        if (!rst_n) lows++;
        chk(lows == 0, "R2 no reset below limit", lows, 0);
        sup_ok = 1'b0;
        edges_until(1'b0, 20, k);
        chk(k == 3, "R2 one good sample undoes one count", k, 3);
    endtask

    // R6: balanced alternation holds, bad-dominant duty resets
    task automatic t_shallow(int l);
        int lows = 0;
        int k = -1;
        for (int i = 0; i < 100; i++) begin
            sup_ok = 1'b0;
            step(1);
            if (!rst_n) lows++;
            sup_ok = 1'b1;
            step(1);
            if (!rst_n) lows++;
        end
        chk(lows == 0, "R6 alternation leaves reset high", lows, 0);
        for (int e = 1; e <= 100; e++) begin
            sup_ok = (e % 3 == 0);
            step(1);
            if (!rst_n) begin
                k = e;
                break;
            end
        end
        chk(k == 3 * l - 3, "R6 duty-cycle fault edge", k, 3 * l - 3);
        sup_ok = 1'b0;
        step(l + 2);
    endtask

    // R7: fault during release delay restarts the delay
    task automatic t_restart(int l, int d);
        int k;
        int highs = 0;
        sup_ok = 1'b1;
        for (int i = 0; i < l + 2; i++) begin
            step(1);
            if (rst_n) highs++;
        end
        sup_ok = 1'b0;
        for (int i = 0; i < l; i++) begin
            step(1);
            if (rst_n) highs++;
        end
        chk(highs == 0, "R7 reset held through aborted release", highs, 0);
        sup_ok = 1'b1;
        edges_until(1'b1, l + d + 20, k);
        chk(k == l + d, "R7 full delay after abort", k, l + d);
    endtask

    initial begin
        clr_n = 1'b0;
        sup_ok = 1'b0;
        lim = '0;
        dly = '0;
        step(2);

        t_powerup(4, 10);
        t_transient(4);
        t_updown(4);
        t_powerup(4, 10);
        t_shallow(4);
        t_powerup(4, 10);
        t_fault(4);
        t_restart(4, 10);
        t_fault(4);
        t_powerup(3, 1);
        t_fault(3);
        t_powerup(0, 0);
        t_fault(0);
        t_powerup(6, 37);
        t_transient(6);
        t_fault(6);
        t_restart(6, 37);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule